// File: doc/BRIEF.md
# Switchable Power Domain Controller

This block controls a set of switchable power domains. Each domain can have a power switch, an interconnect idle handshake, or both. Software reaches every control and status bit through a small register bus. Writing a domain's power request bit starts a timed transition. The domain's power status flips only after a programmable number of cycles has passed. A separate count register sets that number for each direction. Idle requests go to a modelled interconnect responder for each domain. The responder returns an acknowledge and, somewhat later, an idle status.

Domains are configured at elaboration with two masks: one marks which domains own a power switch, the other marks which own an idle handshake. A bit that belongs to a missing feature reads as zero, and writes to it are dropped. The register bus has no back-pressure. Every access is taken in the cycle where `bus_valid` is high. A write takes effect at that clock edge. Read data is combinational and is valid in the same cycle as the read.

Top module: `pdu_unit`

## Requirements
- R1: After reset, every domain reads as powered (power status 0) with power request 0. Idle request, acknowledge and idle status read 0. Both transition count registers read 24.
- R2: Register 0x00 holds one power request bit per domain: 1 asks for off, 0 asks for on. Register 0x04 holds the power status, one bit per domain: 0 means powered, 1 means off.
- R3: For a request written at clock edge E, power status shows the new state from edge E+N+1. N is the down count when going off and the up count when going on. A count of 0 behaves as 1. The count is captured when the transition starts.
- R4: A request that changes while a transition is pending restarts the timer in the newly requested direction. The earlier timing is dropped, so status does not change at the moment the old transition would have ended.
- R5: The down count sits at 0x10 and the up count at 0x14 (down base plus 4). Each holds CNT_W bits, and both read back what was written.
- R6: Register 0x08 holds one idle request bit per domain. Register 0x0C returns idle status for domain n at bit n and the acknowledge at bit n+16. A request written at edge E asserts the acknowledge from edge E+1 and the idle status from edge E+1+IDLE_LAT.
- R7: Clearing an idle request at edge E drops both the acknowledge and the idle status from edge E+1.
- R8: For a domain without a switch, its power request and status bits read 0 and ignore writes. For a domain without an idle handshake, its idle request, acknowledge and status bits read 0 and ignore writes.
- R9: Reads from unmapped offsets return 0. Writes to 0x04, 0x0C or an unmapped offset change nothing.
- R10: When no read is in progress (`bus_valid` low or `bus_write` high), `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when no read |

## Verification
Directed sequences check the transition timer exactly at the cycle before and the cycle of each status flip. They cover the down count, the up count, a zero count, and two kinds of reversal while a transition is pending. Reversal is the case that separates a timer that restarts from one that keeps its old deadline or ignores the change. Seeded random request masks with random counts cover many mixes of domains and tell correct masking of switch-less and handshake-less domains apart from leaks across lanes. Cycle-exact idle traces separate the acknowledge lane from the status lane and verify the IDLE_LAT gap between them.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
  // Register byte offsets
  localparam int unsigned OFF_PWR_REQ  = 32'h00;
  localparam int unsigned OFF_PWR_STAT = 32'h04;
  localparam int unsigned OFF_IDL_REQ  = 32'h08;
  localparam int unsigned OFF_IDL_STAT = 32'h0C;
  localparam int unsigned OFF_CNT_DOWN = 32'h10;
  localparam int unsigned OFF_CNT_UP   = OFF_CNT_DOWN + 4;
  // Bit lane where acknowledge bits start in the idle status register
  localparam int unsigned ACK_LANE     = 16;
endpackage

// File: rtl/pdu_switch.sv
module pdu_switch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_req,
  input  logic [CNT_W-1:0] down_cnt,
  input  logic [CNT_W-1:0] up_cnt,
  output logic             stat_off
);
  logic             stat_q, busy_q, tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = off_req ? down_cnt : up_cnt;
    if (load_val == '0) load_val = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      busy_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && (off_req != tgt_q)) begin
      tgt_q <= off_req;
      cnt_q <= load_val;
    end else if (!busy_q && (off_req != stat_q)) begin
      busy_q <= 1'b1;
      tgt_q  <= off_req;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        stat_q <= tgt_q;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign stat_off = stat_q;

  AST_STAT_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != $past(stat_q)) |-> ($past(busy_q) && $past(cnt_q) == CNT_W'(1))); // R3

  AST_PENDING_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && off_req != stat_q) |=> busy_q); // R4
endmodule

// File: rtl/pdu_idle.sv
module pdu_idle #(
  parameter int IDLE_LAT = 2,
  localparam int LAT_W = $clog2(IDLE_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack,
  output logic idle
);
  logic             ack_q, idle_q;
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      idle_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!req) begin
      ack_q  <= 1'b0;
      idle_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ack_q <= 1'b1;
      if (ack_q && !idle_q) begin
        if (cnt_q == LAT_W'(IDLE_LAT - 1)) idle_q <= 1'b1;
        else cnt_q <= cnt_q + LAT_W'(1);
      end
    end
  end

  assign ack  = ack_q;
  assign idle = idle_q;

  AST_IDLE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> ack_q); // R6

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!ack_q && !idle_q)); // R7
endmodule

// File: rtl/pdu_regs.sv
module pdu_regs
  import pdu_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int DEF_CNT = 24,
  parameter logic [NUM_DOM-1:0] PWR_MASK  = 4'b0111,
  parameter logic [NUM_DOM-1:0] IDLE_MASK = 4'b1101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_DOM-1:0] pwr_req,
  output logic [NUM_DOM-1:0] idle_req,
  output logic [CNT_W-1:0]   down_cnt,
  output logic [CNT_W-1:0]   up_cnt,
  input  logic [NUM_DOM-1:0] stat_off,
  input  logic [NUM_DOM-1:0] idle_ack,
  input  logic [NUM_DOM-1:0] idle_stat
);
  logic              wr_en, rd_en;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_req  <= '0;
      idle_req <= '0;
      down_cnt <= CNT_W'(DEF_CNT);
      up_cnt   <= CNT_W'(DEF_CNT);
    end else if (wr_en) begin
      if (bus_addr == ADDR_W'(OFF_PWR_REQ)) pwr_req  <= bus_wdata[NUM_DOM-1:0] & PWR_MASK;
      if (bus_addr == ADDR_W'(OFF_IDL_REQ)) idle_req <= bus_wdata[NUM_DOM-1:0] & IDLE_MASK;
      if (bus_addr == ADDR_W'(OFF_CNT_DOWN)) down_cnt <= bus_wdata[CNT_W-1:0];
      if (bus_addr == ADDR_W'(OFF_CNT_UP))   up_cnt   <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_PWR_REQ))  rd_mux[NUM_DOM-1:0] = pwr_req;
    if (bus_addr == ADDR_W'(OFF_PWR_STAT)) rd_mux[NUM_DOM-1:0] = stat_off;
    if (bus_addr == ADDR_W'(OFF_IDL_REQ))  rd_mux[NUM_DOM-1:0] = idle_req;
    if (bus_addr == ADDR_W'(OFF_IDL_STAT)) begin
      rd_mux[NUM_DOM-1:0]        = idle_stat;
      rd_mux[ACK_LANE +: NUM_DOM] = idle_ack;
    end
    if (bus_addr == ADDR_W'(OFF_CNT_DOWN)) rd_mux[CNT_W-1:0] = down_cnt;
    if (bus_addr == ADDR_W'(OFF_CNT_UP))   rd_mux[CNT_W-1:0] = up_cnt;
  end

  assign bus_rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/pdu_unit.sv
module pdu_unit #(
  parameter int NUM_DOM  = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 16,
  parameter int DEF_CNT  = 24,
  parameter int IDLE_LAT = 2,
  parameter logic [NUM_DOM-1:0] PWR_MASK  = 4'b0111,
  parameter logic [NUM_DOM-1:0] IDLE_MASK = 4'b1101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [NUM_DOM-1:0] pwr_req, idle_req, stat_off, idle_ack, idle_stat;
  logic [CNT_W-1:0]   down_cnt, up_cnt;

  pdu_regs #(
    .NUM_DOM(NUM_DOM), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .DEF_CNT(DEF_CNT), .PWR_MASK(PWR_MASK), .IDLE_MASK(IDLE_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_req(pwr_req), .idle_req(idle_req),
    .down_cnt(down_cnt), .up_cnt(up_cnt),
    .stat_off(stat_off), .idle_ack(idle_ack), .idle_stat(idle_stat)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (PWR_MASK[d]) begin : g_sw
      pdu_switch #(.CNT_W(CNT_W)) u_sw (
        .clk(clk), .rst_n(rst_n), .off_req(pwr_req[d]),
        .down_cnt(down_cnt), .up_cnt(up_cnt), .stat_off(stat_off[d])
      );
    end else begin : g_nosw
      logic unused_req;
      assign unused_req  = pwr_req[d];
      assign stat_off[d] = 1'b0;
    end

    if (IDLE_MASK[d]) begin : g_idl
      pdu_idle #(.IDLE_LAT(IDLE_LAT)) u_idl (
        .clk(clk), .rst_n(rst_n), .req(idle_req[d]),
        .ack(idle_ack[d]), .idle(idle_stat[d])
      );
    end else begin : g_noidl
      logic unused_ireq;
      assign unused_ireq  = idle_req[d];
      assign idle_ack[d]  = 1'b0;
      assign idle_stat[d] = 1'b0;
    end
  end
endmodule

// File: tb/tb_pdu_unit.sv
module tb_pdu_unit;
  localparam int ND = 4;
  localparam int IL = 2;
  localparam logic [3:0] PM = 4'b0111;
  localparam logic [3:0] IM = 4'b1101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pdu_unit #(.IDLE_LAT(IL), .PWR_MASK(PM), .IDLE_MASK(IM)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] exp_stat(logic [3:0] r);
    return {28'd0, r & PM};
  endfunction
  function automatic logic [31:0] exp_idle(logic [3:0] r);
    logic [31:0] v = '0;
    v[3:0]   = r & IM;
    v[19:16] = r & IM;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // Called just after a falling edge; no clock edge passes.
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // Called just after a falling edge; uses the next rising edge, returns after the following falling edge.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic idle_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED1));
    idle_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rchk("R1 pwr_req", 8'h00, 0);
    rchk("R1 pwr_stat", 8'h04, 0);
    rchk("R1 idle_req", 8'h08, 0);
    rchk("R1 idle_stat", 8'h0C, 0);
    rchk("R1 down_cnt", 8'h10, 24);
    rchk("R1 up_cnt", 8'h14, 24);

    // R9 unmapped and read-only writes
    rchk("R9 unmapped read", 8'h1C, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rchk("R9 stat after write", 8'h04, 0);
    rchk("R9 idle stat after write", 8'h0C, 0);
    rchk("R9 unmapped after write", 8'h20, 0);

    // R10 no read in progress
    bus_addr = 8'h10; #1;
    chk("R10 idle rdata", bus_rdata, 0);
    bus_write = 1'b1; bus_valid = 1'b1; bus_addr = 8'h44; #1;
    chk("R10 write rdata", bus_rdata, 0);
    bus_valid = 1'b0; bus_write = 1'b0;
    @(negedge clk);

    // R5 count registers
    wr(8'h10, 5);
    wr(8'h14, 3);
    rchk("R5 down readback", 8'h10, 5);
    rchk("R5 up readback", 8'h14, 3);

    // R3 power-down timing, domain 0
    wr(8'h00, 1);
    idle_cyc(5);
    rchk("R3 down not early", 8'h04, 0);
    idle_cyc(1);
    rchk("R3/R2 down lands", 8'h04, 1);
    // R3 power-up timing
    wr(8'h00, 0);
    idle_cyc(3);
    rchk("R3 up not early", 8'h04, 1);
    idle_cyc(1);
    rchk("R3/R2 up lands", 8'h04, 0);
    // R3 zero count acts as one
    wr(8'h10, 0);
    wr(8'h00, 1);
    idle_cyc(1);
    rchk("R3 zero count early", 8'h04, 0);
    idle_cyc(1);
    rchk("R3 zero count lands", 8'h04, 1);
    wr(8'h14, 1);
    wr(8'h00, 0);
    idle_cyc(4);
    rchk("R3 back on", 8'h04, 0);

    // R4 reversal back to current state
    wr(8'h10, 12);
    wr(8'h14, 3);
    wr(8'h00, 1);
    idle_cyc(4);
    wr(8'h00, 0);
    idle_cyc(9);
    rchk("R4 reversal keeps on", 8'h04, 0);
    // R4 restart toward off
    wr(8'h00, 1);
    idle_cyc(3);
    wr(8'h00, 0);
    idle_cyc(1);
    wr(8'h00, 1);
    idle_cyc(12);
    rchk("R4 restart not early", 8'h04, 0);
    idle_cyc(1);
    rchk("R4 restart lands", 8'h04, 1);
    wr(8'h00, 0);
    idle_cyc(6);
    rchk("R4 restore", 8'h04, 0);

    // R8 masked domains (domain 3 no switch, domain 1 no handshake)
    wr(8'h00, 32'hF);
    rchk("R8 pwr_req masked", 8'h00, 32'h7);
    idle_cyc(16);
    rchk("R8/R2 stat masked", 8'h04, 32'h7);
    wr(8'h00, 0);
    idle_cyc(6);
    wr(8'h08, 32'hF);
    rchk("R8 idle_req masked", 8'h08, 32'hD);
    idle_cyc(IL + 3);
    rchk("R8/R6 idle stat masked", 8'h0C, 32'h000D_000D);
    wr(8'h08, 0);
    idle_cyc(2);

    // R6 / R7 idle timing on domain 2 (status bit 2, ack bit 18)
    wr(8'h08, 4);
    rchk("R6 ack not early", 8'h0C, 0);
    idle_cyc(1);
    rchk("R6 ack asserted", 8'h0C, 32'h0004_0000);
    idle_cyc(IL - 1);
    rchk("R6 idle not early", 8'h0C, 32'h0004_0000);
    idle_cyc(1);
    rchk("R6 idle asserted", 8'h0C, 32'h0004_0004);
    wr(8'h08, 0);
    rchk("R7 held at clear edge", 8'h0C, 32'h0004_0004);
    idle_cyc(1);
    rchk("R7 both dropped", 8'h0C, 0);

    // Random mixes
    for (int i = 0; i < 24; i++) begin
      logic [3:0] r, q;
      r = 4'($urandom);
      q = 4'($urandom);
      wr(8'h10, 1 + ($urandom % 15));
      wr(8'h14, 1 + ($urandom % 15));
      wr(8'h00, {28'd0, r});
      idle_cyc(20);
      rchk("R2 random stat", 8'h04, exp_stat(r));
      rchk("R8 random req", 8'h00, exp_stat(r));
      wr(8'h08, {28'd0, q});
      idle_cyc(IL + 3);
      rchk("R6 random idle", 8'h0C, exp_idle(q));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule